// File: doc/BRIEF.md
# Indirect Flash Access Bridge

The bridge gives a processor a byte-level path to an external serial flash through a small register window. Four byte-wide address registers together form a 32-bit pointer, with the register at select 3 as the most significant byte. A fifth location is the data port. The top nibble of the pointer names the target device. The bridge answers only for the internal flash, whose identifier is a parameter with a default of 4.

In normal mode, reading the data port runs a complete serial read transaction. The bridge lowers chip select and sends the read opcode. It then sends the low 24 address bits, most significant byte first, and shifts in one more byte while sending a fill pattern. It raises chip select afterwards and returns the byte received.

The bridge enters a pass-through mode while the pointer has the form `0x?FFFxxxx`, with the target nibble valid. In this mode, a write to the data port with address bits [15:8] equal to `0xFD` lowers chip select and shifts the written byte out. A write with those bits equal to `0xFE` raises chip select without any transfer. A read shifts in one byte and returns it. Software therefore builds any flash command frame byte by byte. It leaves this mode by rewriting the top byte with only the target nibble and clearing address bits [23:16].

Every processor access is held with a ready handshake until its work, including any serial transfers, is finished. The bit-level serializer sits outside the block and is driven through a start/done byte interface.

Top module: `flash_indirect_bridge`

## Requirements
- R1: After reset, chip select is high (inactive), `cpu_ready` and `sh_start` are low, and all four address registers read back as 0.
- R2: Selects 0 to 3 address the pointer bytes, from least to most significant. Each one can be written and read back. A read of selects 5 to 7 returns 0, and a write to them changes nothing.
- R3: The requester holds `cpu_req` until the bridge answers. Each access is answered by `cpu_ready` high for exactly one cycle. A register access is answered on the first clock edge after the request is taken. `sh_start` only pulses while a request is pending.
- R4: In normal mode, a data-port read with the target nibble valid lowers chip select. It then transfers the bytes 0x03, pointer[23:16], pointer[15:8], pointer[7:0] and 0xFF, in that order, and returns the byte shifted in during the last transfer. Chip select is high again when ready is given, and the pointer is left unchanged.
- R5: When pointer[31:28] is not the target identifier, a data-port read returns 0xFF with no serial transfer, and chip select stays high.
- R6: Pass-through mode is active only while pointer[31:28] is the target identifier, pointer[27:24] is 0xF and pointer[23:16] is 0xFF. If any one of these three conditions fails, the bridge behaves as in normal mode.
- R7: In pass-through mode, a data-port write with pointer[15:8] = 0xFD drives chip select low and transfers exactly the written byte.
- R8: In pass-through mode, a data-port write with pointer[15:8] = 0xFE drives chip select high and starts no transfer.
- R9: In pass-through mode, a data-port read transfers one byte with 0xFF sent out and returns the byte shifted in. Chip select keeps its level.
- R10: In pass-through mode, a data-port write with any other value in pointer[15:8] starts no transfer and leaves chip select unchanged.
- R11: In normal mode, data-port writes start no transfer and leave chip select unchanged.
- R12: Rewriting the top byte to the bare target nibble (0x40 by default) and clearing pointer[23:16] returns the bridge to normal-mode reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 3 | Register select: 0-3 pointer bytes, 4 data port |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle access completion |
| flash_cs_n | output | 1 | Flash chip select, active low |
| sh_start | output | 1 | One-cycle request for a byte transfer |
| sh_tx | output | 8 | Byte to send, valid with sh_start |
| sh_done | input | 1 | One-cycle transfer completion from the serializer |
| sh_rx | input | 8 | Byte received, valid with sh_done |

## Verification
The bench targets the places where mode decoding can go wrong.

It uses pointers that match only two of the three pass-through conditions. A decoder that checks only the low nibble of the top byte would then shift bytes out where it should ignore them.

It checks the exact byte order of the hardware read frame. It also checks that chip select is high again once the read is answered. A design that reuses a stale index would send the wrong address bytes. A design that fails to raise chip select would merge two reads into one frame.

In pass-through mode it drives both magic pages, a neutral page and reads. A design that toggles chip select on the neutral page, or on a read, shows up in the chip-select level and in the transfer log.

// File: rtl/flash_indirect_bridge.sv
module flash_indirect_bridge #(
  parameter logic [3:0] TARGET_ID  = 4'h4,
  parameter logic [7:0] READ_OP    = 8'h03,
  parameter logic [7:0] CS_HI_PAGE = 8'hFE,
  parameter logic [7:0] CS_LO_PAGE = 8'hFD,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic [2:0] cpu_sel,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       cpu_ready,
  output logic       flash_cs_n,
  output logic       sh_start,
  output logic [7:0] sh_tx,
  input  logic       sh_done,
  input  logic [7:0] sh_rx
);

  localparam logic [2:0] SEL_DATA  = 3'd4;
  localparam logic [2:0] LAST_BYTE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} state_t;
  typedef enum logic [1:0] {K_READ, K_PWR, K_PRD} kind_t;

  state_t          state;
  kind_t           kind;
  logic [3:0][7:0] ptr;
  logic [2:0]      idx;

  wire target_ok = ptr[3][7:4] == TARGET_ID;
  wire pass_mode = target_ok && ptr[3][3:0] == 4'hF && ptr[2] == 8'hFF;
  wire take      = state == S_IDLE && cpu_req;
  wire reg_wr    = take && cpu_we && !cpu_sel[2];

  assign cpu_ready = state == S_DONE;

  function automatic logic [7:0] frame_byte(input logic [2:0] n, input logic [3:0][7:0] p);
    case (n)
      3'd1:    return p[2];
      3'd2:    return p[1];
      3'd3:    return p[0];
      default: return FILL_BYTE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= K_READ;
      ptr        <= '0;
      idx        <= '0;
      flash_cs_n <= 1'b1;
      sh_start   <= 1'b0;
      sh_tx      <= '0;
      cpu_rdata  <= '0;
    end else begin
      sh_start <= 1'b0;
      case (state)
        S_IDLE: if (cpu_req) begin
          state <= S_DONE;
          if (cpu_sel != SEL_DATA) begin
            if (cpu_we) begin
              if (!cpu_sel[2]) ptr[cpu_sel[1:0]] <= cpu_wdata;
            end else begin
              cpu_rdata <= cpu_sel[2] ? 8'h00 : ptr[cpu_sel[1:0]];
            end
          end else if (cpu_we) begin
            if (pass_mode && ptr[1] == CS_HI_PAGE) begin
              flash_cs_n <= 1'b1;
            end else if (pass_mode && ptr[1] == CS_LO_PAGE) begin
              flash_cs_n <= 1'b0;
              sh_start   <= 1'b1;
              sh_tx      <= cpu_wdata;
              kind       <= K_PWR;
              state      <= S_WAIT;
            end
          end else if (pass_mode) begin
            sh_start <= 1'b1;
            sh_tx    <= FILL_BYTE;
            kind     <= K_PRD;
            state    <= S_WAIT;
          end else if (target_ok) begin
            flash_cs_n <= 1'b0;
            sh_start   <= 1'b1;
            sh_tx      <= READ_OP;
            idx        <= '0;
            kind       <= K_READ;
            state      <= S_WAIT;
          end else begin
            cpu_rdata <= FILL_BYTE;
          end
        end
        S_WAIT: if (sh_done) begin
          if (kind == K_READ && idx != LAST_BYTE) begin
            idx      <= idx + 3'd1;
            sh_start <= 1'b1;
            sh_tx    <= frame_byte(idx + 3'd1, ptr);
          end else begin
            state <= S_DONE;
            if (kind != K_PWR) cpu_rdata <= sh_rx;
            if (kind == K_READ) flash_cs_n <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_start_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> cpu_req);

  p_ready_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |=> !sh_start);

  p_ptr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ptr));

  p_cs_low_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && kind == K_READ) |-> !flash_cs_n);

  p_cs_fall_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n) |-> $past(cpu_req && cpu_sel == SEL_DATA));

endmodule

// File: tb/flash_indirect_bridge_tb.sv
module flash_indirect_bridge_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cpu_req = 0, cpu_we = 0;
  logic [2:0] cpu_sel = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic       cpu_ready, flash_cs_n, sh_start;
  logic [7:0] sh_tx;
  logic       sh_done = 0;
  logic [7:0] sh_rx = 0;

  int total = 0, bad = 0;
  int nsh = 0, pos = 0, cnt = 0, lat = 0;
  bit busy = 0;
  logic [7:0] txlog [64];
  logic [7:0] cmd = 0, status_val = 8'h02, rxval = 0;
  logic [23:0] fa = 0;

  always #2 clk = ~clk;

  flash_indirect_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .flash_cs_n(flash_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx));

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    sh_done = 0;
    if (flash_cs_n) pos = 0;
    if (busy) begin
      cnt = cnt - 1;
      if (cnt == 0) begin busy = 0; sh_done = 1; sh_rx = rxval; end
    end
    if (sh_start) begin
      txlog[nsh % 64] = sh_tx;
      nsh = nsh + 1;
      if (pos >= 4 && cmd == 8'h03) rxval = mem(fa + 24'(pos - 4));
      else rxval = status_val;
      case (pos)
        0: cmd = sh_tx;
        1: fa[23:16] = sh_tx;
        2: fa[15:8] = sh_tx;
        3: fa[7:0] = sh_tx;
        default: ;
      endcase
      pos = pos + 1;
      busy = 1;
      cnt = 3;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [2:0] sel, input logic [7:0] wd,
                     output logic [7:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_sel = sel; cpu_wdata = wd;
    lat = 0;
    forever begin
      @(posedge clk); #1;
      lat++;
      if (cpu_ready) break;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic set_ptr(input logic [31:0] p);
    logic [7:0] d;
    for (int i = 0; i < 4; i++) acc(1, 3'(i), p[8*i +: 8], d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1", flash_cs_n, 1, "cs after reset");
    chk("R1", cpu_ready, 0, "ready after reset");
    chk("R1", sh_start, 0, "start after reset");
    for (int i = 0; i < 4; i++) begin
      acc(0, 3'(i), 0, d);
      chk("R1", d, 0, "pointer byte after reset");
    end
  endtask

  task automatic t_regs;
    logic [7:0] d;
    set_ptr(32'hA1B2C3D4);
    chk("R3", lat, 1, "register write latency");
    for (int i = 0; i < 4; i++) begin
      acc(0, 3'(i), 0, d);
      chk("R2", d, 32'hA1B2C3D4 >> (8*i) & 32'hFF, "pointer byte readback");
    end
    chk("R3", lat, 1, "register read latency");
    acc(1, 3'd6, 8'h77, d);
    acc(0, 3'd6, 0, d);
    chk("R2", d, 0, "unused select reads zero");
    acc(0, 3'd3, 0, d);
    chk("R2", d, 8'hA1, "unused select write leaves pointer");
  endtask

  task automatic t_read(input logic [31:0] p);
    logic [7:0] d;
    int n0;
    set_ptr(p);
    n0 = nsh;
    acc(0, 3'd4, 0, d);
    chk("R4", nsh - n0, 5, "read frame length");
    chk("R4", txlog[n0 % 64], 8'h03, "opcode");
    chk("R4", txlog[(n0+1) % 64], p[23:16], "address high");
    chk("R4", txlog[(n0+2) % 64], p[15:8], "address mid");
    chk("R4", txlog[(n0+3) % 64], p[7:0], "address low");
    chk("R4", txlog[(n0+4) % 64], 8'hFF, "fill byte");
    chk("R4", d, mem(p[23:0]), "read data");
    chk("R4", flash_cs_n, 1, "cs high after read");
    acc(0, 3'd1, 0, d);
    chk("R4", d, p[15:8], "pointer unchanged by read");
  endtask

  task automatic t_other_target;
    logic [7:0] d;
    int n0;
    set_ptr(32'h30123456);
    n0 = nsh;
    acc(0, 3'd4, 0, d);
    chk("R5", d, 8'hFF, "foreign target read");
    chk("R5", nsh - n0, 0, "no transfer on foreign target");
    chk("R5", flash_cs_n, 1, "cs stays high on foreign target");
  endtask

  task automatic t_normal_write;
    logic [7:0] d;
    int n0;
    set_ptr(32'h4012FD00);
    n0 = nsh;
    acc(1, 3'd4, 8'h99, d);
    chk("R11", nsh - n0, 0, "normal write no transfer");
    chk("R11", flash_cs_n, 1, "normal write cs");
    set_ptr(32'h4F12FD00);
    acc(1, 3'd4, 8'h99, d);
    chk("R6", nsh - n0, 0, "mid byte not FF is normal mode");
    set_ptr(32'h3FFFFD00);
    acc(1, 3'd4, 8'h99, d);
    chk("R6", nsh - n0, 0, "wrong target is not pass mode");
    chk("R6", flash_cs_n, 1, "cs untouched outside pass mode");
    set_ptr(32'h4EFFFD00);
    acc(1, 3'd4, 8'h99, d);
    chk("R6", nsh - n0, 0, "low nibble not F is normal mode");
  endtask

  task automatic t_pass;
    logic [7:0] d;
    int n0;
    set_ptr(32'h4FFFFE00);
    n0 = nsh;
    acc(1, 3'd4, 8'h00, d);
    chk("R8", flash_cs_n, 1, "cs high page");
    chk("R8", nsh - n0, 0, "cs high page no transfer");
    acc(1, 3'd1, 8'hFD, d);
    acc(1, 3'd4, 8'h06, d);
    chk("R7", flash_cs_n, 0, "cs low page");
    chk("R7", nsh - n0, 1, "one byte out");
    chk("R7", txlog[n0 % 64], 8'h06, "byte out value");
    acc(1, 3'd1, 8'hFE, d);
    acc(1, 3'd4, 8'h00, d);
    chk("R8", flash_cs_n, 1, "cs raised again");
    chk("R8", nsh - n0, 1, "raise cs no transfer");
    acc(1, 3'd1, 8'hFD, d);
    acc(1, 3'd4, 8'h05, d);
    status_val = 8'h3C;
    acc(0, 3'd4, 0, d);
    chk("R9", d, 8'h3C, "pass read data");
    chk("R9", nsh - n0, 3, "pass read one transfer");
    chk("R9", txlog[(n0+2) % 64], 8'hFF, "pass read sends fill");
    chk("R9", flash_cs_n, 0, "pass read keeps cs");
    acc(1, 3'd1, 8'h77, d);
    acc(1, 3'd4, 8'h55, d);
    chk("R10", nsh - n0, 3, "neutral page no transfer");
    chk("R10", flash_cs_n, 0, "neutral page keeps cs");
    acc(1, 3'd1, 8'hFE, d);
    acc(1, 3'd4, 8'h00, d);
    chk("R8", flash_cs_n, 1, "final cs high");
  endtask

  task automatic t_exit;
    logic [7:0] d;
    int n0;
    acc(1, 3'd3, 8'h40, d);
    acc(1, 3'd2, 8'h00, d);
    acc(1, 3'd1, 8'hFD, d);
    acc(1, 3'd0, 8'h21, d);
    n0 = nsh;
    acc(0, 3'd4, 0, d);
    chk("R12", nsh - n0, 5, "normal frame after exit");
    chk("R12", d, mem(24'h00FD21), "data after exit");
    chk("R12", flash_cs_n, 1, "cs after exit read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog: actual=hung expected=ready");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_read(32'h40123456);
    t_read(32'h40ABCDEF);
    t_other_target;
    t_normal_write;
    t_pass;
    t_exit;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule